// File: doc/BRIEF.md
# Host I/O to RAM Window Mapper

This block sits between a host-side I/O cycle decoder and the embedded controller's RAM. Each host I/O request carries a 12-bit address inside a 4 KB host-visible range. The block compares that address against two programmable windows. A hit becomes a RAM cycle in a 4 KB page of controller RAM that software selects. The low 12 address bits pass through unchanged. For example, host address 800h reaches offset 800h of the selected page.

Each window has a base with 16-byte granularity and a power-of-two length between 16 and 2048 bytes. Each window can be made read-only. Software programs a small byte-wide register file to set the page, the windows, the protection and the enables. A read hit returns its byte one cycle after the request, marked by a valid strobe. A small two-state machine tracks that pending read. In `ST_IDLE` no read return is due. A read hit moves the machine to `ST_RD_PEND`, the cycle in which the data returns. A further read hit keeps it in `ST_RD_PEND`. Any other cycle takes it back to `ST_IDLE`.

Top module: `hram_window_map`

## Requirements
- R1: After reset every register reads zero, both windows are disabled, and `h_rvalid` is low.
- R2: Register file layout and write masks:
  - Control at 5Ah keeps bits 0, 1 and 4. Bit 0 enables window 0, bit 1 enables window 1, and bit 4 enables routing of host I/O cycles.
  - Window bases are at 5Bh (window 0) and 5Ch (window 1). Each holds host address bits [11:4].
  - Window size registers are at 5Dh (window 0) and 5Eh (window 1). Each keeps bits 5:4 as protect and bits 2:0 as the size code.
  - The page register at 5Fh keeps bits 3:0.
  - Bits that are not kept read zero, and unmapped offsets read zero.
- R3: A request hits window w when three conditions hold: window w is enabled, routing bit 4 is set, and the address lies in [base*16, base*16 + (16 << code)). `h_hit` is high in the same cycle as the request.
- R4: A request that misses both windows keeps `h_hit`, `ram_re` and `ram_we` low.
- R5: For a hit, `ram_addr` is {page[3:0], h_addr[11:0]}.
- R6: When both protect bits (5:4) of the hitting window are set, a write hit keeps `h_hit` high but does not assert `ram_we`. With only one of the two bits set, the window stays writable.
- R7: Where the windows overlap, window 0 decides the hit, including its protection.
- R8: A read hit asserts `ram_re` in the request cycle. `h_rvalid` and the RAM byte on `h_rdata` follow one cycle later. Back-to-back read hits return back-to-back bytes. `h_rdata` is zero when `h_rvalid` is low.
- R9: An unprotected write hit asserts `ram_we` in the request cycle, with `ram_wdata` equal to `h_wdata`.
- R10: A cycle with both `h_rd` and `h_wr` high is treated as a read only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| h_addr | input | 12 | Host I/O address within the 4 KB range |
| h_rd | input | 1 | Host read request |
| h_wr | input | 1 | Host write request |
| h_wdata | input | 8 | Host write data |
| h_hit | output | 1 | Request hits an enabled window |
| h_rvalid | output | 1 | Read data valid |
| h_rdata | output | 8 | Read data |
| ram_addr | output | 16 | RAM byte address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |

## Verification
The bench builds the block with its default widths: a 12-bit host range, a 4-bit page field and a 16-byte base granularity. With these widths, every one of the 4096 host addresses and every size code from 16 to 2048 bytes can be reached in a short run. Directed cases place windows on exact edges, including the byte just below a base, the last byte inside a window and the first byte past it. Other directed cases cover overlapping windows with differing protection, and the largest window, whose end runs past the top of the range. A randomized stream of mixed reads and writes around the windows then exercises back-to-back read returns against a behavioural RAM image held in the bench.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
    localparam int LOW_W    = 12;
    localparam int PAGE_W   = 4;
    localparam int RAM_AW   = LOW_W + PAGE_W;
    localparam int DW       = 8;
    localparam int RA_W     = 8;
    localparam int NWIN     = 2;
    localparam int SZ_W     = 3;
    localparam int GRAN_LOG = 4;
    localparam int BASE_W   = LOW_W - GRAN_LOG;

    localparam logic [RA_W-1:0] OFS_CTRL  = 8'h5A;
    localparam logic [RA_W-1:0] OFS_BASE0 = 8'h5B;
    localparam logic [RA_W-1:0] OFS_SIZE0 = 8'h5D;
    localparam logic [RA_W-1:0] OFS_PAGE  = 8'h5F;

    localparam int CTRL_ROUTE = 4;
    localparam logic [DW-1:0] CTRL_MASK = 8'h13;
    localparam logic [DW-1:0] SIZE_MASK = 8'h37;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
        logic [SZ_W-1:0]   code;
        logic [1:0]        wp;
    } win_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RD_PEND = 1'b1
    } acc_state_e;
endpackage

// File: rtl/hwm_regs.sv
module hwm_regs
    import hwm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [RA_W-1:0]       reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    output win_cfg_t [NWIN-1:0]   cfg,
    output logic                  route,
    output logic [PAGE_W-1:0]     page
);
    logic [DW-1:0]     ctrl_q;
    logic [DW-1:0]     base_q [NWIN];
    logic [DW-1:0]     size_q [NWIN];
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            page_q <= '0;
            for (int w = 0; w < NWIN; w++) begin
                base_q[w] <= '0;
                size_q[w] <= '0;
            end
        end else if (reg_wr) begin
            if (reg_addr == OFS_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
            if (reg_addr == OFS_PAGE) page_q <= reg_wdata[PAGE_W-1:0];
            for (int w = 0; w < NWIN; w++) begin
                if (reg_addr == OFS_BASE0 + RA_W'(w)) base_q[w] <= reg_wdata;
                if (reg_addr == OFS_SIZE0 + RA_W'(w)) size_q[w] <= reg_wdata & SIZE_MASK;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL) reg_rdata = ctrl_q;
        if (reg_addr == OFS_PAGE) reg_rdata = DW'(page_q);
        for (int w = 0; w < NWIN; w++) begin
            if (reg_addr == OFS_BASE0 + RA_W'(w)) reg_rdata = base_q[w];
            if (reg_addr == OFS_SIZE0 + RA_W'(w)) reg_rdata = size_q[w];
        end
    end

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_cfg
            assign cfg[g].en   = ctrl_q[g];
            assign cfg[g].base = base_q[g][BASE_W-1:0];
            assign cfg[g].code = size_q[g][SZ_W-1:0];
            assign cfg[g].wp   = size_q[g][5:4];
        end
    endgenerate

    assign route = ctrl_q[CTRL_ROUTE];
    assign page  = page_q;
endmodule

// File: rtl/hwm_win_match.sv
module hwm_win_match
    import hwm_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic              route,
    input  logic [LOW_W-1:0]  addr,
    output logic              hit,
    output logic              prot
);
    logic [LOW_W:0] lo;
    logic [LOW_W:0] span;
    logic [LOW_W:0] hi;
    logic [LOW_W:0] a_ext;

    always_comb begin
        lo    = {1'b0, cfg.base, {GRAN_LOG{1'b0}}};
        span  = (LOW_W+1)'(1) << (int'(cfg.code) + GRAN_LOG);
        hi    = lo + span;
        a_ext = {1'b0, addr};
        hit   = cfg.en && route && (a_ext >= lo) && (a_ext < hi);
        prot  = &cfg.wp;
    end
endmodule

// File: rtl/hwm_access_fsm.sv
module hwm_access_fsm
    import hwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    output logic rvalid
);
    acc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = rd_hit ? ST_RD_PEND : ST_IDLE;
            ST_RD_PEND: state_d = rd_hit ? ST_RD_PEND : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE:    rvalid = 1'b0;
            ST_RD_PEND: rvalid = 1'b1;
            default:    rvalid = 1'b0;
        endcase
    end
endmodule

// File: rtl/hram_window_map.sv
module hram_window_map
    import hwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [LOW_W-1:0]  h_addr,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [DW-1:0]     h_wdata,
    output logic              h_hit,
    output logic              h_rvalid,
    output logic [DW-1:0]     h_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata
);
    win_cfg_t [NWIN-1:0] cfg;
    logic                route;
    logic [PAGE_W-1:0]   page;
    logic [NWIN-1:0]     hit_v;
    logic [NWIN-1:0]     prot_v;
    logic                any_hit;
    logic                prot_sel;
    logic                req;
    logic                rvalid;

    hwm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg),
        .route(route), .page(page)
    );

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            hwm_win_match u_match (
                .cfg(cfg[g]), .route(route), .addr(h_addr),
                .hit(hit_v[g]), .prot(prot_v[g])
            );
        end
    endgenerate

    // lowest-numbered window wins on overlap
    always_comb begin
        any_hit  = 1'b0;
        prot_sel = 1'b0;
        for (int w = NWIN-1; w >= 0; w--) begin
            if (hit_v[w]) begin
                any_hit  = 1'b1;
                prot_sel = prot_v[w];
            end
        end
    end

    assign req       = h_rd || h_wr;
    assign h_hit     = req && any_hit;
    assign ram_re    = h_rd && any_hit;
    assign ram_we    = h_wr && !h_rd && any_hit && !prot_sel;
    assign ram_addr  = {page, h_addr};
    assign ram_wdata = h_wdata;

    hwm_access_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_hit(ram_re), .rvalid(rvalid)
    );

    assign h_rvalid = rvalid;
    assign h_rdata  = rvalid ? ram_rdata : '0;
endmodule

// File: rtl/hwm_checker.sv
module hwm_checker
    import hwm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              h_rd,
    input logic              h_wr,
    input logic [LOW_W-1:0]  h_addr,
    input logic              h_hit,
    input logic              h_rvalid,
    input logic              ram_re,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr
);
    a_r4_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !h_hit |-> (!ram_re && !ram_we));

    a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && h_hit) |=> h_rvalid);

    a_r8_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |-> $past(h_rd && h_hit));

    a_r9_we_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (h_wr && !h_rd && h_hit));

    a_r5_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_re || ram_we) |-> (ram_addr[LOW_W-1:0] == h_addr));

    a_r10_single_cycle_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_re && ram_we));
endmodule

bind hram_window_map hwm_checker chk_i (
    .clk(clk), .rst_n(rst_n), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
    .h_hit(h_hit), .h_rvalid(h_rvalid), .ram_re(ram_re), .ram_we(ram_we),
    .ram_addr(ram_addr)
);

// File: tb/hram_window_map_tb_top.sv
module hram_window_map_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [11:0] h_addr = 12'h000;
    logic        h_rd = 1'b0;
    logic        h_wr = 1'b0;
    logic [7:0]  h_wdata = 8'h00;
    logic        h_hit;
    logic        h_rvalid;
    logic [7:0]  h_rdata;
    logic [15:0] ram_addr;
    logic        ram_re;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = 8'h00;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    hram_window_map dut_i (.*);

    // ---------- behavioural RAM attached to the design ----------
    byte unsigned emem [int];
    function automatic byte unsigned pat(int a);
        return 8'((a ^ (a >> 8) ^ 8'hA5) & 8'hFF);
    endfunction

    always @(posedge clk) begin
        if (ram_we) emem[int'(ram_addr)] = ram_wdata;
        if (ram_re) ram_rdata <= emem.exists(int'(ram_addr)) ? emem[int'(ram_addr)] : pat(int'(ram_addr));
    end

    // ---------- reference model ----------
    byte unsigned m_ctrl = 0, m_page = 0;
    byte unsigned m_base [2] = '{0, 0};
    byte unsigned m_size [2] = '{0, 0};
    byte unsigned mmem [int];
    bit           exp_rv = 1'b0;
    byte unsigned exp_rd = 0;

    function automatic int m_win(int a);
        for (int w = 0; w < 2; w++) begin
            int lo = int'(m_base[w]) * 16;
            int sz = 16 << (m_size[w] & 7);
            if (m_ctrl[w] && m_ctrl[4] && a >= lo && a < lo + sz) return w;
        end
        return -1;
    endfunction

    function automatic byte unsigned m_reg(byte unsigned a);
        case (a)
            8'h5A: return m_ctrl;
            8'h5B: return m_base[0];
            8'h5C: return m_base[1];
            8'h5D: return m_size[0];
            8'h5E: return m_size[1];
            8'h5F: return m_page;
            default: return 0;
        endcase
    endfunction

    function automatic int m_ram_addr(int a);
        return int'(m_page) * 4096 + a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_rv = 0; m_ctrl = 0; m_page = 0;
            m_base = '{0, 0}; m_size = '{0, 0};
        end else begin
            int w;
            int ra;
            w  = (h_rd || h_wr) ? m_win(int'(h_addr)) : -1;
            ra = m_ram_addr(int'(h_addr));
            exp_rv = h_rd && (w >= 0);
            exp_rd = mmem.exists(ra) ? mmem[ra] : pat(ra);
            if (h_wr && !h_rd && w >= 0 && (m_size[w] & 8'h30) != 8'h30) mmem[ra] = h_wdata;
            if (reg_wr) begin
                case (reg_addr)
                    8'h5A: m_ctrl = reg_wdata & 8'h13;
                    8'h5B: m_base[0] = reg_wdata;
                    8'h5C: m_base[1] = reg_wdata;
                    8'h5D: m_size[0] = reg_wdata & 8'h37;
                    8'h5E: m_size[1] = reg_wdata & 8'h37;
                    8'h5F: m_page = reg_wdata & 8'h0F;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", tag, cur_tag, $time, act, exp);
        end
    endtask

    // ---------- per-cycle comparison, mid-cycle ----------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int  w;
            bit  ehit, ere, ewe;
            w    = (h_rd || h_wr) ? m_win(int'(h_addr)) : -1;
            ehit = (w >= 0);
            ere  = h_rd && ehit;
            ewe  = h_wr && !h_rd && ehit && ((m_size[ehit ? w : 0] & 8'h30) != 8'h30);
            chk("R3 h_hit", h_hit, ehit);
            chk("R8 ram_re", ram_re, ere);
            chk("R6/R9 ram_we", ram_we, ewe);
            if (ere || ewe) chk("R5 ram_addr", ram_addr, m_ram_addr(int'(h_addr)));
            if (ewe) chk("R9 ram_wdata", ram_wdata, h_wdata);
            chk("R8 h_rvalid", h_rvalid, exp_rv);
            chk("R8 h_rdata", h_rdata, exp_rv ? exp_rd : 0);
            chk("R2 reg_rdata", reg_rdata, m_reg(reg_addr));
        end
    end

    // ---------- stimulus helpers ----------
    task automatic reg_set(byte unsigned a, byte unsigned d);
        @(posedge clk); #2;
        h_rd = 0; h_wr = 0; reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic reg_look(byte unsigned a);
        @(posedge clk); #2;
        h_rd = 0; h_wr = 0; reg_wr = 0; reg_addr = a;
    endtask

    task automatic host(bit rd, bit wr, int a, byte unsigned d);
        @(posedge clk); #2;
        reg_wr = 0; h_rd = rd; h_wr = wr; h_addr = 12'(a); h_wdata = d;
    endtask

    task automatic idle();
        @(posedge clk); #2;
        reg_wr = 0; h_rd = 0; h_wr = 0;
    endtask

    // ---------- watchdog ----------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------- main sequence ----------
    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk("R1 rvalid in reset", h_rvalid, 0);
        chk("R1 ctrl in reset", reg_rdata, 0);
        @(posedge clk); #2; rst_n = 1;
        cur_tag = "R1";
        for (int a = 8'h5A; a <= 8'h5F; a++) reg_look(byte'(a));
        cur_tag = "R4";
        host(1, 0, 12'h800, 0); host(0, 1, 12'h000, 8'h11); idle();

        cur_tag = "R2";
        reg_set(8'h5A, 8'hFF); reg_look(8'h5A);
        reg_set(8'h5D, 8'hFF); reg_look(8'h5D);
        reg_set(8'h5F, 8'hFF); reg_look(8'h5F);
        reg_set(8'h40, 8'hFF); reg_look(8'h40);

        cur_tag = "R3";
        reg_set(8'h5A, 8'h03);
        reg_set(8'h5F, 8'h03);
        reg_set(8'h5B, 8'h80); reg_set(8'h5D, 8'h04);
        reg_set(8'h5C, 8'h90); reg_set(8'h5E, 8'h32);
        host(1, 0, 12'h810, 0);          // route off: miss
        reg_set(8'h5A, 8'h13);
        cur_tag = "R9";
        host(0, 1, 12'h800, 8'h3C); host(0, 1, 12'h8FF, 8'hC3);
        cur_tag = "R8";
        host(1, 0, 12'h800, 0); host(1, 0, 12'h8FF, 0); host(1, 0, 12'h900, 0); idle();
        cur_tag = "R3";
        host(1, 0, 12'h7FF, 0); host(1, 0, 12'h93F, 0); host(1, 0, 12'h940, 0); idle();
        cur_tag = "R6";
        host(0, 1, 12'h910, 8'h77); host(1, 0, 12'h910, 0);
        reg_set(8'h5E, 8'h12);
        host(0, 1, 12'h910, 8'h78); host(1, 0, 12'h910, 0); idle();
        cur_tag = "R5";
        reg_set(8'h5F, 8'h0A);
        host(0, 1, 12'h820, 8'h5E); host(1, 0, 12'h820, 0); idle();
        cur_tag = "R7";
        reg_set(8'h5C, 8'h80); reg_set(8'h5E, 8'h37);
        host(0, 1, 12'h810, 8'h91); host(0, 1, 12'h950, 8'h92);
        host(1, 0, 12'h810, 0); host(1, 0, 12'h950, 0); host(1, 0, 12'hFFF, 0); idle();
        cur_tag = "R10";
        host(1, 1, 12'h830, 8'hEE); host(1, 0, 12'h830, 0); idle();

        cur_tag = "R8";
        reg_set(8'h5C, 8'h9C); reg_set(8'h5E, 8'h01);
        for (int i = 0; i < 400; i++) begin
            int a = 12'h7C0 + int'($urandom_range(0, 12'h27F));
            int k = int'($urandom_range(0, 3));
            host(k[0], k == 2, a, 8'($urandom));
        end
        idle(); idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule